// File: doc/BRIEF.md
# Presettable Cascadable Up/Down Counter

This block is a fully synchronous binary counter with a default width of four bits. It counts up or down modulo 2^WIDTH and can be preset to any value from a parallel data bus. Loads and counts take effect only on the rising clock edge. An active-low load input takes precedence over counting. Counting needs two active-low enables, one parallel and one trickle, both asserted together. A direction input selects increment or decrement.

An active-low terminal-count output is decoded combinationally from the stored count, the direction and the trickle enable. It flags all-ones when counting up and all-zeros when counting down. To cascade stages, all stages share the clock and the parallel enable, and each stage's terminal count drives the trickle enable of the stage above it. A wide count then advances across every stage on the same clock edge. An optional synchronous active-low reset clears the count for test purposes. In normal use the counter is initialised with a load.

Top module: `presettable_updn_counter`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `q` becomes all zeros after that edge, whatever the other inputs are.
- R2: When `rst_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din` after that edge. This happens whatever the levels of `cnt_par_n`, `cnt_trk_n` and `up` are.
- R3: When `load_n` is high, `cnt_par_n` and `cnt_trk_n` are both low and `up` is 1 at an edge, `q` increments by one. The all-ones value wraps to zero.
- R4: When `load_n` is high, `cnt_par_n` and `cnt_trk_n` are both low and `up` is 0 at an edge, `q` decrements by one. Zero wraps to all ones.
- R5: When `load_n` is high and either `cnt_par_n` or `cnt_trk_n` is high at an edge, `q` keeps its value.
- R6: `term_n` is low only while `cnt_trk_n` is low and one of two conditions holds: `up` is 1 with `q` all ones, or `up` is 0 with `q` all zeros. Otherwise `term_n` is high. It follows changes on `up` and `cnt_trk_n` without waiting for a clock edge.
- R7: `term_n` does not depend on `cnt_par_n` or `load_n`.
- R8: Two stages can be chained. They share the clock, `load_n`, `cnt_par_n` and `up`. The upper stage's `cnt_trk_n` is driven by the lower stage's `term_n`. Chained this way, the pair acts as one counter of twice the width that counts up or down with wrap-around and is loaded through both `din` buses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all state changes |
| rst_n | input | 1 | Synchronous active-low test reset to zero |
| load_n | input | 1 | Active-low synchronous parallel load |
| din | input | WIDTH | Value loaded when `load_n` is low |
| cnt_par_n | input | 1 | Active-low count enable shared by all stages |
| cnt_trk_n | input | 1 | Active-low count enable that also gates `term_n` |
| up | input | 1 | Direction: 1 increments, 0 decrements |
| q | output | WIDTH | Current count |
| term_n | output | 1 | Active-low terminal-count flag for cascading |

## Verification
The bench builds three instances, all with the default WIDTH of 4. The single instance has only 16 states, so both wrap boundaries, both terminal decodes and every load value are reached in a few cycles. The two chained instances form an 8-bit counter, which exercises the carry and borrow between stages on the 0x0F/0x10 and 0xFF/0x00 boundaries. A pseudo-random stretch of loads, counts and holds with a toggling direction compares the count and the terminal flag against a model on every cycle.

// File: rtl/updn_cnt_pkg.sv
// Package: shared operation encoding for the up/down counter.
// Assumes: consumers only compare against the named values.
package updn_cnt_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } updn_op_e;

endpackage

// File: rtl/updn_op_select.sv
// Module: picks this cycle's operation from the control pins.
// Assumes: load outranks counting; counting needs both enables low.
module updn_op_select
    import updn_cnt_pkg::*;
(
    input  logic     load_n,
    input  logic     cnt_par_n,
    input  logic     cnt_trk_n,
    input  logic     up,
    output updn_op_e op
);

    // Priority decode of load, count direction and hold.
    always_comb begin
        if (!load_n) begin
            op = OP_LOAD;
        end else if (!cnt_par_n && !cnt_trk_n) begin
            op = up ? OP_INC : OP_DEC;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/updn_next_state.sv
// Module: computes the next count with a per-bit lookahead toggle chain.
// Assumes: wrap-around is modulo 2^WIDTH; op is a valid encoding.
module updn_next_state
    import updn_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    input  updn_op_e         op,
    output logic [WIDTH-1:0] nxt
);

    logic             dir_up;
    logic [WIDTH-1:0] toggle;

    // Direction used by the toggle chain.
    assign dir_up = (op == OP_INC);

    // Bit i toggles when every lower bit is 1 (up) or 0 (down).
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_chain
            if (i == 0) begin : g_lsb
                assign toggle[i] = 1'b1;
            end else begin : g_upper
                assign toggle[i] = toggle[i-1] &
                                   (dir_up ? cur[i-1] : ~cur[i-1]);
            end
        end
    endgenerate

    // Selects the next stored value for the chosen operation.
    always_comb begin
        unique case (op)
            OP_LOAD: nxt = din;
            OP_INC,
            OP_DEC:  nxt = cur ^ toggle;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/updn_term_detect.sv
// Module: combinational active-low terminal-count decode.
// Assumes: gated by the trickle enable only; may glitch, never a clock.
module updn_term_detect #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             up,
    input  logic             cnt_trk_n,
    output logic             term_n
);

    logic at_top;
    logic at_bottom;

    // End-of-range detection in each direction.
    assign at_top    = &q;
    assign at_bottom = ~|q;

    // Flag is low only with the trickle enable asserted at the range end.
    assign term_n = ~(~cnt_trk_n & (up ? at_top : at_bottom));

endmodule

// File: rtl/presettable_updn_counter.sv
// Module: presettable synchronous up/down counter, cascadable via term_n.
// Assumes: all changes on the rising edge; rst_n is a synchronous test reset.
module presettable_updn_counter
    import updn_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             cnt_par_n,
    input  logic             cnt_trk_n,
    input  logic             up,
    output logic [WIDTH-1:0] q,
    output logic             term_n
);

    updn_op_e         op;
    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] count_d;

    updn_op_select u_sel (
        .load_n    (load_n),
        .cnt_par_n (cnt_par_n),
        .cnt_trk_n (cnt_trk_n),
        .up        (up),
        .op        (op)
    );

    updn_next_state #(.WIDTH(WIDTH)) u_next (
        .cur (count_q),
        .din (din),
        .op  (op),
        .nxt (count_d)
    );

    // Count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    updn_term_detect #(.WIDTH(WIDTH)) u_term (
        .q         (count_q),
        .up        (up),
        .cnt_trk_n (cnt_trk_n),
        .term_n    (term_n)
    );

    assign q = count_q;

endmodule

// File: rtl/updn_cnt_checker.sv
// Module: assertion checker bound to the counter top.
// Assumes: same clock; rst_n is synchronous and active low.
module updn_cnt_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             cnt_par_n,
    input logic             cnt_trk_n,
    input logic             up,
    input logic [WIDTH-1:0] q,
    input logic             term_n
);

    logic rst_seen_q;

    // Remembers that reset was low at the previous edge.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // R1: reset at the previous edge leaves the count at zero.
    always @(posedge clk) begin
        if (rst_seen_q === 1'b1) begin
            a_r1_reset_zero: assert (q == '0)
                else $error("a_r1_reset_zero");
        end
    end

    a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> q == $past(din));

    a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_par_n && !cnt_trk_n && up)
        |=> q == WIDTH'($past(q) + 1'b1));

    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_par_n && !cnt_trk_n && !up)
        |=> q == WIDTH'($past(q) - 1'b1));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && (cnt_par_n || cnt_trk_n)) |=> $stable(q));

    a_r6_term_needs_trickle: assert property (@(posedge clk) disable iff (!rst_n)
        !term_n |-> !cnt_trk_n);

    a_r6_term_range_end: assert property (@(posedge clk) disable iff (!rst_n)
        !term_n |-> (up ? (q == {WIDTH{1'b1}}) : (q == '0)));

endmodule

bind presettable_updn_counter updn_cnt_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .din       (din),
    .cnt_par_n (cnt_par_n),
    .cnt_trk_n (cnt_trk_n),
    .up        (up),
    .q         (q),
    .term_n    (term_n)
);

// File: tb/presettable_updn_counter_test.sv
// Bench: directed scenario tasks on one counter plus a two-stage cascade.
module presettable_updn_counter_test;

    logic       clk = 1'b0;
    logic       rst_n, load_n, cnt_par_n, cnt_trk_n, up;
    logic [3:0] din, q;
    logic       term_n;

    logic       c_load_n, c_par_n, c_up, c_trk_n;
    logic [7:0] c_din;
    logic [3:0] lo_q, hi_q;
    logic       lo_term, hi_term;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    presettable_updn_counter #(.WIDTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
        .cnt_par_n(cnt_par_n), .cnt_trk_n(cnt_trk_n), .up(up),
        .q(q), .term_n(term_n));

    presettable_updn_counter #(.WIDTH(4)) u_lo (
        .clk(clk), .rst_n(rst_n), .load_n(c_load_n), .din(c_din[3:0]),
        .cnt_par_n(c_par_n), .cnt_trk_n(c_trk_n), .up(c_up),
        .q(lo_q), .term_n(lo_term));

    presettable_updn_counter #(.WIDTH(4)) u_hi (
        .clk(clk), .rst_n(rst_n), .load_n(c_load_n), .din(c_din[7:4]),
        .cnt_par_n(c_par_n), .cnt_trk_n(lo_term), .up(c_up),
        .q(hi_q), .term_n(hi_term));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(logic l, logic p, logic t, logic u, logic [3:0] d);
        @(negedge clk);
        load_n = l; cnt_par_n = p; cnt_trk_n = t; up = u; din = d;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        drive(1'b0, 1'b0, 1'b0, 1'b1, 4'h9);
        rst_n = 1'b0;
        tick();
        chk("R1 reset beats load", q, 4'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_load();
        drive(1'b0, 1'b0, 1'b0, 1'b1, 4'hA);
        tick();
        chk("R2 load with counting enabled", q, 4'hA);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 4'h5);
        tick();
        chk("R2 load with enables off", q, 4'h5);
    endtask

    task automatic t_up_wrap();
        drive(1'b0, 1'b1, 1'b1, 1'b1, 4'hD);
        tick();
        drive(1'b1, 1'b0, 1'b0, 1'b1, 4'h0);
        tick(); chk("R3 up 13->14", q, 4'hE);
        tick(); chk("R3 up 14->15", q, 4'hF);
        chk("R6 term at 15 counting up", term_n, 1'b0);
        tick(); chk("R3 wrap 15->0", q, 4'h0);
        chk("R6 term released after wrap", term_n, 1'b1);
    endtask

    task automatic t_down_wrap();
        drive(1'b0, 1'b1, 1'b1, 1'b0, 4'h2);
        tick();
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h0);
        tick(); chk("R4 down 2->1", q, 4'h1);
        tick(); chk("R4 down 1->0", q, 4'h0);
        chk("R6 term at 0 counting down", term_n, 1'b0);
        tick(); chk("R4 wrap 0->15", q, 4'hF);
    endtask

    task automatic t_hold();
        drive(1'b0, 1'b1, 1'b1, 1'b1, 4'h7);
        tick();
        drive(1'b1, 1'b1, 1'b0, 1'b1, 4'h3);
        tick(); chk("R5 hold parallel enable high", q, 4'h7);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 4'h3);
        tick(); chk("R5 hold trickle enable high", q, 4'h7);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 4'h3);
        tick(); chk("R5 hold both high", q, 4'h7);
    endtask

    task automatic t_term();
        drive(1'b0, 1'b1, 1'b1, 1'b1, 4'hF);
        tick();
        drive(1'b1, 1'b1, 1'b0, 1'b1, 4'h0);
        #1; chk("R6 15 up trickle low", term_n, 1'b0);
        cnt_trk_n = 1'b1; #1;
        chk("R6 trickle high masks flag", term_n, 1'b1);
        cnt_trk_n = 1'b0; up = 1'b0; #1;
        chk("R6 15 counting down", term_n, 1'b1);
        up = 1'b1; cnt_par_n = 1'b0; load_n = 1'b0; din = 4'hF; #1;
        chk("R7 parallel enable and load ignored", term_n, 1'b0);
        cnt_par_n = 1'b1; #1;
        chk("R7 parallel enable high", term_n, 1'b0);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 4'h0);
        tick();
        drive(1'b1, 1'b1, 1'b0, 1'b0, 4'h0);
        #1; chk("R6 0 down trickle low", term_n, 1'b0);
        up = 1'b1; #1;
        chk("R6 0 counting up", term_n, 1'b1);
    endtask

    task automatic cdrive(logic l, logic p, logic u, logic [7:0] d);
        @(negedge clk);
        c_load_n = l; c_par_n = p; c_up = u; c_din = d; c_trk_n = 1'b0;
    endtask

    task automatic t_cascade();
        cdrive(1'b0, 1'b1, 1'b1, 8'h0E);
        tick();
        chk("R8 cascade load", {hi_q, lo_q}, 8'h0E);
        cdrive(1'b1, 1'b0, 1'b1, 8'h00);
        tick(); chk("R8 cascade up", {hi_q, lo_q}, 8'h0F);
        tick(); chk("R8 cascade carry 0F->10", {hi_q, lo_q}, 8'h10);
        cdrive(1'b0, 1'b1, 1'b1, 8'hFE);
        tick();
        cdrive(1'b1, 1'b0, 1'b1, 8'h00);
        tick(); chk("R8 cascade reach FF", {hi_q, lo_q}, 8'hFF);
        chk("R8 upper flag at FF", hi_term, 1'b0);
        tick(); chk("R8 cascade wrap FF->00", {hi_q, lo_q}, 8'h00);
        cdrive(1'b1, 1'b0, 1'b0, 8'h00);
        tick(); chk("R8 cascade borrow 00->FF", {hi_q, lo_q}, 8'hFF);
        tick(); chk("R8 cascade down FF->FE", {hi_q, lo_q}, 8'hFE);
        cdrive(1'b1, 1'b1, 1'b0, 8'h00);
        tick(); chk("R8 cascade hold", {hi_q, lo_q}, 8'hFE);
    endtask

    task automatic t_random();
        logic [15:0] lfsr = 16'hACE1;
        logic [3:0]  model = q;
        logic        exp_t;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[0] & lfsr[1] & lfsr[2], lfsr[3] & lfsr[4], lfsr[5] & lfsr[6],
                  lfsr[7], lfsr[11:8]);
            #1;
            exp_t = ~(~cnt_trk_n & (up ? (model == 4'hF) : (model == 4'h0)));
            chk("R6 random term", term_n, exp_t);
            if (!load_n)                       model = din;
            else if (!cnt_par_n && !cnt_trk_n) model = up ? model + 4'd1 : model - 4'd1;
            tick();
            chk("R2/R3/R4/R5 random count", q, model);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        drive(1'b1, 1'b1, 1'b1, 1'b1, 4'h0);
        cdrive(1'b1, 1'b1, 1'b1, 8'h00);
        t_reset();
        chk("R1 cascade reset", {hi_q, lo_q}, 8'h00);
        t_load();
        t_up_wrap();
        t_down_wrap();
        t_hold();
        t_term();
        t_cascade();
        t_random();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule